// File: doc/BRIEF.md
# I2C Master Condition Sequencer

This block is the control front end of an I2C master. It holds four control bits: enable, a request for a START condition, a request for a STOP condition, and a timer mode. From these bits it decides when the bit-level engine may drive a START, a repeated START or a STOP on the bus. That decision depends on whether a byte is ready to send, whether a byte and its acknowledge are still in flight, and whether another master is addressing this device as a slave. The engine reports back each condition it has driven, and the matching request bit then clears.

Software sets the request bits by writing ones. Writing zeros never withdraws a request; only hardware clears them. When a START request runs into slave activity, the block cancels the request and sets a sticky arbitration-lost flag. While the controller is disabled, the same block can run its baud-rate counter as a free-running periodic interrupt timer.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset the control bits, the arbitration-lost flag, both condition requests and the interrupt are all 0.
- R2: A control write uses these bits: bit 0 is enable (plain read/write), bit 1 is the START request, bit 2 is the STOP request and bit 3 is timer mode (plain read/write). Writing 0 to bit 1 or bit 2 while that request is pending has no effect.
- R3: A write that clears enable also clears both pending requests in the same cycle.
- R4: `req_start` is asserted only while `data_avail` is 1. A START request made with no data available stays pending and is issued once data arrives.
- R5: The START request bit clears on the clock edge where `start_done` is sampled high.
- R6: While `xfer_busy` is 1, neither request is issued. A START requested during a transfer is issued as a repeated START once `xfer_busy` falls.
- R7: While a STOP request is pending, `req_start` stays low. With both requests pending, STOP is issued first and START follows after `stop_done`.
- R8: STOP is issued only once no byte is in flight, and its request bit clears on the edge where `stop_done` is sampled high.
- R9: A START request that is pending or being written while `slave_active` is 1 is cleared and sets `arb_lost`. A STOP request at such a time is cleared without setting `arb_lost`.
- R10: `arb_lost` stays set until a cycle in which `arb_clr` is 1.
- R11: With enable at 0 and timer mode at 1, `irq` pulses high for one cycle every N cycles, where N is `tmr_reload`. The first pulse comes N cycles after the write that starts the timer.
- R12: A `tmr_reload` of 0 gives a period of 65536 cycles.
- R13: Timer mode is ignored while enable is 1: `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control write data {timer, stop, start, enable} |
| ctl_rdata | output | 4 | Current control bits, same layout |
| arb_clr | input | 1 | Clears the arbitration-lost flag |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| tmr_reload | input | RELOAD_W | Baud counter reload value (0 means 2^RELOAD_W) |
| data_avail | input | 1 | A byte sits in the holding or shift register |
| xfer_busy | input | 1 | A byte or its acknowledge is in progress |
| slave_active | input | 1 | A slave transaction addressed to this device is in progress |
| req_start | output | 1 | Request to the engine to drive START |
| req_stop | output | 1 | Request to the engine to drive STOP |
| start_done | input | 1 | The engine has driven START |
| stop_done | input | 1 | The engine has driven STOP |
| irq | output | 1 | Periodic timer interrupt pulse |

## Verification
The bench sets START and STOP together in the middle of a transfer and checks that STOP is issued first. A design that ignores the pending STOP would drive START while the bus still needs to be released. The bench also requests START with no data and during a busy byte, and checks that no request escapes early; a wrong design would issue a START that has nothing to send, or cut into the acknowledge phase. Slave activity must cancel the requests, with the arbitration flag set for START only. The timer must land on exact cycle numbers for periods of 5, 1 and 0, where 0 means 65536. An off-by-one reload shifts every pulse, and a wrong treatment of zero would give no pulse at all or a pulse on every cycle.

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [3:0]          ctl_wdata,
  output logic [3:0]          ctl_rdata,
  input  logic                arb_clr,
  output logic                arb_lost,
  input  logic [RELOAD_W-1:0] tmr_reload,
  input  logic                data_avail,
  input  logic                xfer_busy,
  input  logic                slave_active,
  output logic                req_start,
  output logic                req_stop,
  input  logic                start_done,
  input  logic                stop_done,
  output logic                irq
);
  localparam int CW = RELOAD_W + 1;

  logic en_q, start_q, stop_q, tmr_q, arb_q, irq_q;
  logic en_nxt, start_set, stop_set, tmr_run;
  logic [CW-1:0] cnt_q, reload_full;

  assign en_nxt    = ctl_wr ? ctl_wdata[0] : en_q;
  assign start_set = ctl_wr & ctl_wdata[1];
  assign stop_set  = ctl_wr & ctl_wdata[2];
  assign tmr_run   = ~en_q & tmr_q;

  assign reload_full = (tmr_reload == '0) ? {1'b1, {RELOAD_W{1'b0}}}
                                          : {1'b0, tmr_reload};

  assign req_stop  = en_q & stop_q & ~xfer_busy & ~slave_active;
  assign req_start = en_q & start_q & ~stop_q & data_avail & ~xfer_busy & ~slave_active;

  assign ctl_rdata = {tmr_q, stop_q, start_q, en_q};
  assign arb_lost  = arb_q;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      tmr_q   <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      en_q    <= en_nxt;
      if (ctl_wr) tmr_q <= ctl_wdata[3];
      start_q <= en_nxt & ~slave_active & ((start_q & ~start_done) | start_set);
      stop_q  <= en_nxt & ~slave_active & ((stop_q & ~stop_done) | stop_set);
      arb_q   <= (arb_q & ~arb_clr) | (en_nxt & slave_active & (start_q | start_set));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tmr_run & (cnt_q == CW'(1));
      if (!tmr_run || cnt_q == CW'(1)) cnt_q <= reload_full;
      else                            cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [3:0] ctl_wdata,
  input logic [3:0] ctl_rdata,
  input logic       arb_clr,
  input logic       arb_lost,
  input logic       data_avail,
  input logic       xfer_busy,
  input logic       slave_active,
  input logic       req_start,
  input logic       req_stop,
  input logic       start_done,
  input logic       irq
);
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[0]) |=> (ctl_rdata[2:1] == 2'b00));

  a_r4_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    req_start |-> data_avail);

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && start_done && !ctl_wr) |=> !ctl_rdata[1]);

  a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> (!req_start && !req_stop));

  a_r7_stop_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_start |-> !ctl_rdata[2]);

  a_r9_slave_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    slave_active |=> (ctl_rdata[2:1] == 2'b00));

  a_r10_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !arb_clr) |=> arb_lost);

  a_r13_no_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] |=> !irq);
endmodule

bind i2c_cond_seq i2c_cond_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .arb_clr(arb_clr), .arb_lost(arb_lost),
  .data_avail(data_avail), .xfer_busy(xfer_busy), .slave_active(slave_active),
  .req_start(req_start), .req_stop(req_stop), .start_done(start_done), .irq(irq)
);

// File: tb/i2c_cond_seq_bench.sv
`timescale 1ns/1ps
module i2c_cond_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [3:0] ctl_rdata;
  logic arb_clr = 1'b0, arb_lost;
  logic [15:0] tmr_reload = 16'd3;
  logic data_avail = 1'b0, xfer_busy = 1'b0, slave_active = 1'b0;
  logic req_start, req_stop;
  logic start_done = 1'b0, stop_done = 1'b0;
  logic irq;

  int nchk = 0, nerr = 0, cyc = 0, irq_cnt = 0;
  byte exp_ev[$];
  int  exp_irq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_cond_seq u_i2c_cond_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .arb_clr(arb_clr), .arb_lost(arb_lost),
    .tmr_reload(tmr_reload), .data_avail(data_avail), .xfer_busy(xfer_busy),
    .slave_active(slave_active), .req_start(req_start), .req_stop(req_stop),
    .start_done(start_done), .stop_done(stop_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic note_ev(input byte ev);
    byte e;
    if (exp_ev.size() == 0) chk(1'b0, "R7 unexpected condition", ev, 0);
    else begin
      e = exp_ev.pop_front();
      chk(ev == e, "R7 condition order", ev, e);
    end
  endtask

  always @(negedge clk) begin
    start_done <= 1'b0;
    stop_done  <= 1'b0;
    if (rst_n && req_start && !start_done) begin
      start_done <= 1'b1;
      note_ev("S");
    end else if (rst_n && req_stop && !stop_done) begin
      stop_done <= 1'b1;
      note_ev("P");
    end
  end

  always @(negedge clk) begin
    int e;
    if (rst_n && irq) begin
      irq_cnt++;
      if (exp_irq.size() == 0) chk(1'b0, "R11 R13 unexpected irq", cyc, -1);
      else begin
        e = exp_irq.pop_front();
        chk(cyc == e, "R11 R12 irq cycle", cyc, e);
      end
    end
  end

  task automatic wr(input logic [3:0] d, output int edge_no);
    ctl_wr = 1'b1; ctl_wdata = d; edge_no = cyc + 1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int w, n0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk(ctl_rdata == 4'b0 && !arb_lost && !irq && !req_start && !req_stop,
        "R1 reset state", {ctl_rdata, arb_lost, irq, req_start, req_stop}, 0);

    wr(4'b0001, w);
    // R4: start waits for data
    wr(4'b0011, w);
    wait_n(5);
    chk(ctl_rdata[1] && !req_start, "R4 start pending without data", ctl_rdata[1], 1);
    exp_ev.push_back("S");
    data_avail = 1'b1;
    wait_n(4);
    chk(ctl_rdata[1] == 1'b0, "R5 start cleared after done", ctl_rdata[1], 0);
    chk(exp_ev.size() == 0, "R4 start issued", exp_ev.size(), 0);

    // R6: repeated start after byte
    xfer_busy = 1'b1;
    wr(4'b0011, w);
    wait_n(5);
    chk(ctl_rdata[1] && !req_start, "R6 start held during byte", req_start, 0);
    exp_ev.push_back("S");
    xfer_busy = 1'b0;
    wait_n(4);
    chk(ctl_rdata[1] == 1'b0 && exp_ev.size() == 0, "R6 repeated start issued", ctl_rdata[1], 0);

    // R7: stop before start
    xfer_busy = 1'b1;
    wr(4'b0111, w);
    wait_n(3);
    chk(ctl_rdata[2:1] == 2'b11, "R7 both pending", ctl_rdata[2:1], 3);
    exp_ev.push_back("P");
    exp_ev.push_back("S");
    xfer_busy = 1'b0;
    wait_n(6);
    chk(ctl_rdata[2:1] == 2'b00 && exp_ev.size() == 0, "R7 both issued", ctl_rdata[2:1], 0);

    // R8: stop waits for byte end
    xfer_busy = 1'b1;
    wr(4'b0101, w);
    wait_n(4);
    chk(ctl_rdata[2] && !req_stop, "R8 stop held during byte", req_stop, 0);
    exp_ev.push_back("P");
    xfer_busy = 1'b0;
    wait_n(3);
    chk(ctl_rdata[2] == 1'b0 && exp_ev.size() == 0, "R8 stop cleared after done", ctl_rdata[2], 0);

    // R2: writing zero keeps requests
    xfer_busy = 1'b1;
    wr(4'b0111, w);
    wr(4'b0001, w);
    wait_n(2);
    chk(ctl_rdata[2:1] == 2'b11, "R2 zero write ignored", ctl_rdata[2:1], 3);

    // R3: disable clears requests
    wr(4'b0000, w);
    wait_n(1);
    chk(ctl_rdata == 4'b0000, "R3 disable clears", ctl_rdata, 0);
    xfer_busy = 1'b0;
    wait_n(4);
    chk(exp_ev.size() == 0 && !req_start && !req_stop, "R3 nothing issued", req_start, 0);
    wr(4'b0001, w);

    // R9: slave activity cancels start
    data_avail = 1'b0;
    wr(4'b0011, w);
    wait_n(2);
    slave_active = 1'b1;
    wait_n(1);
    slave_active = 1'b0;
    wait_n(1);
    chk(ctl_rdata[1] == 1'b0 && arb_lost, "R9 start cancelled, arb set", {ctl_rdata[1], arb_lost}, 1);

    // R10: sticky flag
    wait_n(5);
    chk(arb_lost == 1'b1, "R10 arb sticky", arb_lost, 1);
    arb_clr = 1'b1;
    wait_n(1);
    arb_clr = 1'b0;
    chk(arb_lost == 1'b0, "R10 arb cleared", arb_lost, 0);

    // R9: slave activity cancels stop without arb
    xfer_busy = 1'b1;
    wr(4'b0101, w);
    slave_active = 1'b1;
    wait_n(1);
    slave_active = 1'b0;
    wait_n(1);
    chk(ctl_rdata[2] == 1'b0 && !arb_lost, "R9 stop cancelled, no arb", {ctl_rdata[2], arb_lost}, 0);
    xfer_busy = 1'b0;
    data_avail = 1'b1;

    // R13: timer ignored while enabled
    n0 = irq_cnt;
    wr(4'b1001, w);
    wait_n(30);
    chk(irq_cnt == n0, "R13 no irq when enabled", irq_cnt - n0, 0);

    // R11: period 5
    tmr_reload = 16'd5;
    wr(4'b1000, w);
    exp_irq.push_back(w + 5);
    exp_irq.push_back(w + 10);
    exp_irq.push_back(w + 15);
    wait_n(17);
    wr(4'b0000, w);
    wait_n(3);
    chk(exp_irq.size() == 0, "R11 period 5 pulses", exp_irq.size(), 0);

    // R11: period 1
    tmr_reload = 16'd1;
    n0 = irq_cnt;
    wr(4'b1000, w);
    for (int i = 1; i <= 4; i++) exp_irq.push_back(w + i);
    wait_n(3);
    wr(4'b0000, w);
    wait_n(3);
    chk(irq_cnt - n0 == 4 && exp_irq.size() == 0, "R11 period 1 pulses", irq_cnt - n0, 4);

    // R12: reload zero is 65536
    tmr_reload = 16'd0;
    n0 = irq_cnt;
    wr(4'b1000, w);
    exp_irq.push_back(w + 65536);
    wait_n(65538);
    wr(4'b0000, w);
    wait_n(3);
    chk(irq_cnt - n0 == 1 && exp_irq.size() == 0, "R12 zero reload period", irq_cnt - n0, 1);

    chk(exp_ev.size() == 0, "R7 event queue drained", exp_ev.size(), 0);
    summary();
  end
endmodule